// File: doc/BRIEF.md
# Shared-Register Action Scheduler

This block arbitrates among a fixed set of guarded actions that all want to write one shared register. Each action presents a request flag (its firing condition) and the value it proposes to write. The scheduler decides, in the same cycle, which actions are granted. A mux stage then turns the grants into a write enable and a next value for the register. The register takes the new value on the following clock edge.

The grant policy is fixed when the block is instantiated. In exclusive mode a plain priority encoder grants at most one action per cycle. In ordered mode a conflict matrix parameter says which pairs may not be granted together. Within a conflicting set the lower index wins. Actions that do not conflict are granted together and treated as running in index order, so the highest-index granted action supplies the written value. The grant and data pins are plain level signals with no handshake: a request is either granted in its cycle or dropped, and the requester simply raises it again.

Top module: `rsched_top`

## Requirements
- R1: A grant bit `will_fire[i]` is high only when `can_fire[i]` is high in the same cycle.
- R2: In exclusive mode (`MODE = SCHED_EXCL`) at most one grant is high, and it is the lowest-index asserted request.
- R3: In ordered mode (`MODE = SCHED_SEQ`) two actions i and j whose conflict bit `CONFLICT[i*N_ACT+j]` is 1 are never granted in the same cycle. Of the two, the lower index is preferred.
- R4: In either mode, a requesting action is granted when no lower-index action that conflicts with it is granted. In exclusive mode every pair counts as conflicting.
- R5: When any grant is high, `reg_q` holds the selected value after the next rising clock edge.
- R6: When several grants are high in ordered mode, the written value is that of the highest-index granted action. The value of action i sits in `act_val[i*VAL_W +: VAL_W]`.
- R7: When no grant is high, `reg_q` keeps its value across the clock edge.
- R8: While `rst_n` is low, `reg_q` is `RESET_VAL` (default 0). The grants depend only on the requests, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset for the shared register |
| can_fire | input | N_ACT (4) | Per-action firing condition |
| act_val | input | N_ACT*VAL_W (32) | Proposed values, action i in bits i*VAL_W upward |
| will_fire | output | N_ACT (4) | Per-action grant for this cycle |
| reg_q | output | VAL_W (8) | Shared register contents |

## Verification
The conflict assertions assume that the conflict matrix is symmetric. The stimulus uses the default matrix, where actions 0 and 1 conflict, actions 2 and 3 conflict, and every other pair is composable. The hold and write assertions assume that the request and value inputs are stable around the clock edge. The bench meets this by driving them only on the falling edge. The random request patterns cover all sixteen combinations. Directed cases add all requests high, no request, and pairs of requests that do not conflict. Two instances run side by side, one in each mode.

// File: rtl/rsched_pkg.sv
package rsched_pkg;
  typedef enum logic {
    SCHED_EXCL = 1'b0,
    SCHED_SEQ  = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/rsched_grant.sv
module rsched_grant #(
  parameter int N_ACT = 4,
  parameter rsched_pkg::sched_mode_e MODE = rsched_pkg::SCHED_SEQ,
  parameter logic [N_ACT*N_ACT-1:0] CONFLICT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ACT-1:0] can_fire,
  output logic [N_ACT-1:0] will_fire
);
  logic [N_ACT-1:0] grant;

  generate
    if (MODE == rsched_pkg::SCHED_EXCL) begin : g_excl
      always_comb begin
        grant = '0;
        for (int i = N_ACT - 1; i >= 0; i--) begin
          if (can_fire[i]) grant = N_ACT'(1) << i;
        end
      end
    end else begin : g_seq
      always_comb begin
        logic blocked;
        grant = '0;
        for (int i = 0; i < N_ACT; i++) begin
          blocked = 1'b0;
          for (int j = 0; j < N_ACT; j++) begin
            if (j < i) blocked = blocked | (grant[j] & CONFLICT[i*N_ACT+j]);
          end
          grant[i] = can_fire[i] & ~blocked;
        end
      end
    end
  endgenerate

  assign will_fire = grant;

  // Assertions
  generate
    for (genvar i = 0; i < N_ACT; i++) begin : g_chk
      localparam logic [N_ACT-1:0] LOWER = (N_ACT'(1) << i) - N_ACT'(1);
      a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        will_fire[i] |-> can_fire[i]);
      a_r4_free_req_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (can_fire[i] && ((will_fire & LOWER) == '0)) |-> will_fire[i]);
      if (MODE == rsched_pkg::SCHED_SEQ) begin : g_pair
        for (genvar j = 0; j < i; j++) begin : g_lo
          if (CONFLICT[i*N_ACT+j]) begin : g_cf
            a_r3_no_conflict_pair: assert property (@(posedge clk) disable iff (!rst_n)
              !(will_fire[i] && will_fire[j]));
          end
        end
      end
    end
    if (MODE == rsched_pkg::SCHED_EXCL) begin : g_one
      a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(will_fire));
    end
  endgenerate
endmodule

// File: rtl/rsched_mux.sv
module rsched_mux #(
  parameter int N_ACT = 4,
  parameter int VAL_W = 8,
  parameter rsched_pkg::sched_mode_e MODE = rsched_pkg::SCHED_SEQ
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ACT-1:0]       will_fire,
  input  logic [N_ACT*VAL_W-1:0] act_val,
  output logic                   wr_en,
  output logic [VAL_W-1:0]       wr_val
);
  logic [N_ACT-1:0] sel;

  generate
    for (genvar i = 0; i < N_ACT; i++) begin : g_sel
      if (MODE == rsched_pkg::SCHED_EXCL || i == N_ACT - 1) begin : g_direct
        assign sel[i] = will_fire[i];
      end else begin : g_ordered
        assign sel[i] = will_fire[i] & ~(|will_fire[N_ACT-1:i+1]);
      end
    end
  endgenerate

  always_comb begin
    wr_val = '0;
    for (int i = 0; i < N_ACT; i++) begin
      wr_val = wr_val | (act_val[i*VAL_W +: VAL_W] & {VAL_W{sel[i]}});
    end
  end

  assign wr_en = |will_fire;

  // Assertions
  a_r6_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r5_source_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sel != '0));
endmodule

// File: rtl/rsched_top.sv
module rsched_top #(
  parameter int N_ACT = 4,
  parameter int VAL_W = 8,
  parameter rsched_pkg::sched_mode_e MODE = rsched_pkg::SCHED_SEQ,
  parameter logic [N_ACT*N_ACT-1:0] CONFLICT = 16'h4812,
  parameter logic [VAL_W-1:0] RESET_VAL = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ACT-1:0]       can_fire,
  input  logic [N_ACT*VAL_W-1:0] act_val,
  output logic [N_ACT-1:0]       will_fire,
  output logic [VAL_W-1:0]       reg_q
);
  logic             wr_en;
  logic [VAL_W-1:0] wr_val;

  rsched_grant #(.N_ACT(N_ACT), .MODE(MODE), .CONFLICT(CONFLICT)) u_grant (
    .clk(clk), .rst_n(rst_n), .can_fire(can_fire), .will_fire(will_fire)
  );

  rsched_mux #(.N_ACT(N_ACT), .VAL_W(VAL_W), .MODE(MODE)) u_mux (
    .clk(clk), .rst_n(rst_n), .will_fire(will_fire), .act_val(act_val),
    .wr_en(wr_en), .wr_val(wr_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     reg_q <= RESET_VAL;
    else if (wr_en) reg_q <= wr_val;
  end

  // Assertions
  a_r5_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_q == $past(wr_val)));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));
endmodule

// File: tb/tb_rsched_top.sv
module tb_rsched_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam logic [15:0] CONF = 16'h4812;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] can;
  logic [N*W-1:0] vals;
  logic [N-1:0] will_s, will_x;
  logic [W-1:0] q_s, q_x;
  logic [W-1:0] m_s, m_x;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rsched_top #(.MODE(rsched_pkg::SCHED_SEQ), .CONFLICT(CONF)) dut (
    .clk(clk), .rst_n(rst_n), .can_fire(can), .act_val(vals),
    .will_fire(will_s), .reg_q(q_s));
  rsched_top #(.MODE(rsched_pkg::SCHED_EXCL), .CONFLICT(CONF)) dut_x (
    .clk(clk), .rst_n(rst_n), .can_fire(can), .act_val(vals),
    .will_fire(will_x), .reg_q(q_x));

  function automatic logic [N-1:0] exp_will(logic [N-1:0] c, bit excl);
    logic [N-1:0] g = '0;
    for (int i = 0; i < N; i++) begin
      bit blk = 0;
      for (int j = 0; j < i; j++)
        if (g[j] && (excl || CONF[i*N+j])) blk = 1;
      g[i] = c[i] && !blk;
    end
    return g;
  endfunction

  function automatic logic [W-1:0] exp_next(logic [N-1:0] g, logic [N*W-1:0] v, logic [W-1:0] cur);
    logic [W-1:0] r = cur;
    for (int i = 0; i < N; i++) if (g[i]) r = v[i*W +: W];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] c, logic [N*W-1:0] v, string req);
    logic [N-1:0] gs, gx;
    @(negedge clk);
    can = c; vals = v;
    #1;
    gs = exp_will(c, 0);
    gx = exp_will(c, 1);
    chk({req, " R1 R3 R4 seq grant"}, 32'(will_s), 32'(gs));
    chk({req, " R2 R4 excl grant"}, 32'(will_x), 32'(gx));
    m_s = exp_next(gs, v, m_s);
    m_x = exp_next(gx, v, m_x);
    @(posedge clk); #1;
    chk({req, " R5 R6 R7 seq reg"}, 32'(q_s), 32'(m_s));
    chk({req, " R5 R7 excl reg"}, 32'(q_x), 32'(m_x));
  endtask

  initial begin
    void'($urandom(1234));
    can = '0; vals = '0;
    m_s = '0; m_x = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset value; grants follow requests in reset
    chk("R8 reset seq", 32'(q_s), 32'h0);
    chk("R8 reset excl", 32'(q_x), 32'h0);
    can = 4'b1111; #1;
    chk("R8 grant in reset", 32'(will_s), 32'(4'b0101));
    @(negedge clk); rst_n = 1'b1; can = '0;
    // directed corners
    step(4'b1111, 32'h44332211, "all-req");   // R3: 0 and 2 granted, value of 2
    step(4'b0000, 32'hAABBCCDD, "idle R7");
    step(4'b1010, 32'h80706050, "pair 1,3 R6");
    step(4'b0011, 32'h0F0E0D0C, "conflict 0,1 R3");
    step(4'b1100, 32'h9A8B7C6D, "conflict 2,3 R3");
    step(4'b1001, 32'h12345678, "pair 0,3 R6");
    step(4'b0000, 32'h00000000, "idle2 R7");
    for (int k = 0; k < 400; k++) step(4'($urandom), $urandom, "rand");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule